// File: doc/BRIEF.md
# Overlay and Blink Pixel Mask Stage

This block is the per-pixel stage that sits in front of a color lookup table. Each clock it takes an 8-bit pixel value and two overlay select bits and produces either a masked palette address or an overlay color index, together with a flag that says which of the two the lookup should use. The pixel is always gated by a read mask. During the "off" half of a blink cycle it is also gated by the inverse of a blink mask, so selected bit planes can be made to flash.

A small timer counts vertical-sync pulses to produce the blink on/off phases at one of four rates. An 8-bit command word sets the rate, per-overlay-bit enables, per-overlay-bit blink enables, and the source used when no overlay bit is active. The lookup memory and the analog output are outside this block. All outputs are registered with one cycle of latency, so the address and the overlay index of a pixel leave together.

Top module: `ovb_mask_stage`

## Requirements
- R1: While `rst_n` is low, `pal_addr`, `ovl_sel` and `pal_sel` are all zero, and the blink timer restarts at the first vertical period of the on phase.
- R2: In the blink on phase, `pal_addr` equals `pix_in & read_mask`, taken from the inputs at the previous clock edge.
- R3: In the blink off phase, `pal_addr` equals `pix_in & read_mask & ~blink_mask`. A 1 in `blink_mask` clears that bit and a 0 keeps it.
- R4: `cmd_in[5:4]` selects the blink timing in vertical periods, on phase first: 0 gives 16 on then 48 off, 1 gives 16/16, 2 gives 32/32, 3 gives 64/64, and the pattern repeats.
- R5: The blink timer moves forward by one period only on a rising edge of `vsync_in`. Holding `vsync_in` high or low does not move it.
- R6: A change of `cmd_in[5:4]` restarts the timer at the start of its on phase. The pixel of the clock after the change is already masked as on.
- R7: `cmd_in[0]` and `cmd_in[1]` enable overlay bits 0 and 1. A disabled bit reads as 0 in `ovl_sel`.
- R8: `cmd_in[2]` and `cmd_in[3]` are blink enables for overlay bits 0 and 1. An enabled bit with its blink enable set reads as 0 in the off phase and as its input value in the on phase.
- R9: When the effective overlay value is 0, `cmd_in[6]` picks the source. With the bit set, `pal_sel` is 1 (palette data). With it clear, `pal_sel` is 0 and `ovl_sel` is 0 (overlay color 0).
- R10: A nonzero effective overlay value drives `ovl_sel` to that value and `pal_sel` to 0, whatever `cmd_in[6]` holds.
- R11: Outputs change only at a clock edge, one cycle after their inputs. `pal_addr`, `ovl_sel` and `pal_sel` always belong to the same pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_in | input | 8 | Pixel value |
| ovl_in | input | 2 | Overlay select bits |
| vsync_in | input | 1 | Vertical sync; each rising edge ends one vertical period |
| read_mask | input | 8 | AND mask applied to every pixel |
| blink_mask | input | 8 | Bits cleared during the blink off phase |
| cmd_in | input | 8 | [1:0] overlay enable, [3:2] overlay blink, [5:4] blink rate, [6] palette source when no overlay, [7] unused |
| pal_addr | output | 8 | Masked palette address |
| ovl_sel | output | 2 | Overlay color index (0 when palette or overlay color 0) |
| pal_sel | output | 1 | 1: use palette data at `pal_addr`; 0: use overlay color `ovl_sel` |

## Verification
Every output is due exactly one edge after the inputs that produce it. The bench sets inputs just after a rising edge, computes the expected result from the reference model state before that edge, and compares one time unit after the next edge. A vertical-sync rising edge moves the timer at the edge where it is sampled, so its effect on the masking appears one edge later. The directed blink-length checks therefore apply each pulse as one high cycle plus one low cycle and read the phase after the second cycle. A rate change has its restart visible on the second edge after the change: the first edge still uses the old phase.

// File: rtl/ovb_pkg.sv
`timescale 1ns/1ps
// Package ovb_pkg
// Shared encodings and blink timing helpers for the overlay/blink mask stage.
// Assumes the blink length unit is a count of vertical periods (default 16).
package ovb_pkg;

    localparam int RATE_W = 2;

    // Blink rate encoding carried in the command word
    typedef enum logic [RATE_W-1:0] {
        BR_1ON_3OFF = 2'd0,
        BR_1ON_1OFF = 2'd1,
        BR_2ON_2OFF = 2'd2,
        BR_4ON_4OFF = 2'd3
    } blink_rate_e;

    // Number of vertical periods spent in the on phase
    function automatic int unsigned rate_on_len(input logic [RATE_W-1:0] sel,
                                                input int unsigned unit);
        case (blink_rate_e'(sel))
            BR_1ON_3OFF: return unit;
            BR_1ON_1OFF: return unit;
            BR_2ON_2OFF: return 2 * unit;
            default:     return 4 * unit;
        endcase
    endfunction

    // Full on+off cycle length in vertical periods
    function automatic int unsigned rate_period(input logic [RATE_W-1:0] sel,
                                                input int unsigned unit);
        case (blink_rate_e'(sel))
            BR_1ON_3OFF: return 4 * unit;
            BR_1ON_1OFF: return 2 * unit;
            BR_2ON_2OFF: return 4 * unit;
            default:     return 8 * unit;
        endcase
    endfunction

endpackage

// File: rtl/ovb_blink_timer.sv
`timescale 1ns/1ps
// Module ovb_blink_timer
// Counts rising edges of vertical sync and reports whether the current
// vertical period lies in the blink off phase. A change of rate select
// restarts the count at the first period of the on phase.
// Assumes vsync_in is synchronous to clk.
module ovb_blink_timer #(
    parameter int unsigned UNIT  = 16,
    parameter int          CNT_W = $clog2(8 * UNIT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      vsync_in,
    input  logic [ovb_pkg::RATE_W-1:0] rate_sel,
    output logic                      blink_off,
    output logic [CNT_W-1:0]          count
);
    logic                       vs_q;
    logic [ovb_pkg::RATE_W-1:0] rate_q;
    logic                       vs_rise;
    logic                       rate_chg;
    logic [CNT_W-1:0]           on_len;
    logic [CNT_W-1:0]           last_cnt;

    // Derive edge, rate change and phase limits from stored state
    always_comb begin
        vs_rise  = vsync_in & ~vs_q;
        rate_chg = (rate_sel != rate_q);
        on_len   = CNT_W'(ovb_pkg::rate_on_len(rate_q, UNIT));
        last_cnt = CNT_W'(ovb_pkg::rate_period(rate_q, UNIT) - 1);
    end

    // Advance the period counter, wrap it, or restart it on a rate change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q   <= 1'b0;
            rate_q <= '0;
            count  <= '0;
        end else begin
            vs_q   <= vsync_in;
            rate_q <= rate_sel;
            if (rate_chg) begin
                count <= '0;
            end else if (vs_rise) begin
                count <= (count == last_cnt) ? '0 : count + 1'b1;
            end
        end
    end

    // Off phase covers the counts past the on length
    always_comb begin
        blink_off = (count >= on_len);
    end

endmodule

// File: rtl/ovb_pixel_mask.sv
`timescale 1ns/1ps
// Module ovb_pixel_mask
// Combinational pixel gating: the read mask always applies, the inverted
// blink mask applies only while blink_off is high.
module ovb_pixel_mask #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] pix_in,
    input  logic [PIX_W-1:0] read_mask,
    input  logic [PIX_W-1:0] blink_mask,
    input  logic             blink_off,
    output logic [PIX_W-1:0] pix_out
);
    logic [PIX_W-1:0] keep;

    // Bits allowed through by the blink stage this period
    always_comb begin
        keep = blink_off ? ~blink_mask : {PIX_W{1'b1}};
    end

    // Apply both masks
    always_comb begin
        pix_out = pix_in & read_mask & keep;
    end

endmodule

// File: rtl/ovb_overlay_sel.sv
`timescale 1ns/1ps
// Module ovb_overlay_sel
// Combinational overlay gating and output source choice. Each overlay bit
// is qualified by its enable and, in the off phase, by its blink enable.
// A nonzero result selects that overlay color; otherwise ram_en chooses
// between palette data and overlay color 0.
module ovb_overlay_sel #(
    parameter int OVL_W = 2
) (
    input  logic [OVL_W-1:0] ovl_in,
    input  logic [OVL_W-1:0] ovl_en,
    input  logic [OVL_W-1:0] ovl_blink,
    input  logic             blink_off,
    input  logic             ram_en,
    output logic [OVL_W-1:0] ovl_out,
    output logic             use_pal
);
    logic [OVL_W-1:0] eff;

    // One gating slice per overlay bit
    for (genvar g = 0; g < OVL_W; g++) begin : g_bit
        assign eff[g] = ovl_in[g] & ovl_en[g] & ~(ovl_blink[g] & blink_off);
    end

    // Overlay wins when active; otherwise palette or overlay color 0
    always_comb begin
        if (eff != '0) begin
            ovl_out = eff;
            use_pal = 1'b0;
        end else begin
            ovl_out = '0;
            use_pal = ram_en;
        end
    end

endmodule

// File: rtl/ovb_mask_stage.sv
`timescale 1ns/1ps
// Module ovb_mask_stage
// Top of the overlay and blink pixel mask stage. Splits the command word,
// runs the blink timer, gates pixel and overlay, and registers the result
// with one cycle of latency.
// Assumes all inputs are synchronous to clk; command layout is fixed by
// OVL_W: enables, then blink enables, then rate, then palette source.
module ovb_mask_stage #(
    parameter int          PIX_W = 8,
    parameter int          OVL_W = 2,
    parameter int unsigned UNIT  = 16,
    localparam int         CMD_W = 2 * OVL_W + ovb_pkg::RATE_W + 2,
    localparam int         CNT_W = $clog2(8 * UNIT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_in,
    input  logic [OVL_W-1:0] ovl_in,
    input  logic             vsync_in,
    input  logic [PIX_W-1:0] read_mask,
    input  logic [PIX_W-1:0] blink_mask,
    input  logic [CMD_W-1:0] cmd_in,
    output logic [PIX_W-1:0] pal_addr,
    output logic [OVL_W-1:0] ovl_sel,
    output logic             pal_sel
);
    localparam int EN_LO   = 0;
    localparam int BL_LO   = OVL_W;
    localparam int RATE_LO = 2 * OVL_W;
    localparam int RAM_BIT = RATE_LO + ovb_pkg::RATE_W;

    logic [OVL_W-1:0]           ovl_en;
    logic [OVL_W-1:0]           ovl_blink;
    logic [ovb_pkg::RATE_W-1:0] rate_sel;
    logic                       ram_en;
    logic                       blink_off;
    logic [CNT_W-1:0]           tmr_count;
    logic [PIX_W-1:0]           pix_nxt;
    logic [OVL_W-1:0]           ovl_nxt;
    logic                       pal_nxt;

    // Split the command word into its fields
    always_comb begin
        ovl_en    = cmd_in[EN_LO +: OVL_W];
        ovl_blink = cmd_in[BL_LO +: OVL_W];
        rate_sel  = cmd_in[RATE_LO +: ovb_pkg::RATE_W];
        ram_en    = cmd_in[RAM_BIT];
    end

    ovb_blink_timer #(
        .UNIT  (UNIT),
        .CNT_W (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .vsync_in  (vsync_in),
        .rate_sel  (rate_sel),
        .blink_off (blink_off),
        .count     (tmr_count)
    );

    ovb_pixel_mask #(
        .PIX_W (PIX_W)
    ) u_pix (
        .pix_in     (pix_in),
        .read_mask  (read_mask),
        .blink_mask (blink_mask),
        .blink_off  (blink_off),
        .pix_out    (pix_nxt)
    );

    ovb_overlay_sel #(
        .OVL_W (OVL_W)
    ) u_ovl (
        .ovl_in    (ovl_in),
        .ovl_en    (ovl_en),
        .ovl_blink (ovl_blink),
        .blink_off (blink_off),
        .ram_en    (ram_en),
        .ovl_out   (ovl_nxt),
        .use_pal   (pal_nxt)
    );

    // Register all outputs together so they stay aligned
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pal_addr <= '0;
            ovl_sel  <= '0;
            pal_sel  <= 1'b0;
        end else begin
            pal_addr <= pix_nxt;
            ovl_sel  <= ovl_nxt;
            pal_sel  <= pal_nxt;
        end
    end

endmodule

// File: rtl/ovb_mask_stage_chk.sv
`timescale 1ns/1ps
// Module ovb_mask_stage_chk
// Property checks for ovb_mask_stage, attached with bind below.
module ovb_mask_stage_chk #(
    parameter int PIX_W = 8,
    parameter int OVL_W = 2,
    parameter int CMD_W = 8,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PIX_W-1:0] pix_in,
    input logic [OVL_W-1:0] ovl_in,
    input logic             vsync_in,
    input logic [PIX_W-1:0] read_mask,
    input logic [PIX_W-1:0] blink_mask,
    input logic [CMD_W-1:0] cmd_in,
    input logic [PIX_W-1:0] pal_addr,
    input logic [OVL_W-1:0] ovl_sel,
    input logic             pal_sel,
    input logic             blink_off,
    input logic [CNT_W-1:0] tmr_count
);
    localparam int RATE_LO = 2 * OVL_W;
    localparam int RAM_BIT = RATE_LO + 2;

    AST_PIX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pal_addr == ($past(pix_in) & $past(read_mask) & ($past(blink_off) ? ~$past(blink_mask) : {PIX_W{1'b1}}))); // R3

    for (genvar g = 0; g < OVL_W; g++) begin : g_ovl
        AST_OVL_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(cmd_in[g])) |-> !ovl_sel[g]); // R7
        AST_OVL_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(blink_off) && $past(cmd_in[OVL_W + g])) |-> !ovl_sel[g]); // R8
    end

    AST_OVL_OVERRIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_sel != '0) |-> !pal_sel); // R10

    AST_RAM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ovl_sel == '0) |-> (pal_sel == $past(cmd_in[RAM_BIT]))); // R9

    AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !(vsync_in && !$past(vsync_in)) && cmd_in[RATE_LO +: 2] == $past(cmd_in[RATE_LO +: 2])) |=> $stable(tmr_count)); // R5

    AST_RATE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cmd_in[RATE_LO +: 2] != $past(cmd_in[RATE_LO +: 2])) |=> (tmr_count == '0)); // R6

endmodule

bind ovb_mask_stage ovb_mask_stage_chk #(
    .PIX_W (PIX_W),
    .OVL_W (OVL_W),
    .CMD_W (CMD_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_in     (pix_in),
    .ovl_in     (ovl_in),
    .vsync_in   (vsync_in),
    .read_mask  (read_mask),
    .blink_mask (blink_mask),
    .cmd_in     (cmd_in),
    .pal_addr   (pal_addr),
    .ovl_sel    (ovl_sel),
    .pal_sel    (pal_sel),
    .blink_off  (blink_off),
    .tmr_count  (tmr_count)
);

// File: tb/ovb_mask_stage_bench.sv
`timescale 1ns/1ps
// Bench for ovb_mask_stage: reference model of the requirements, directed
// corner cases and seeded random traffic.
module ovb_mask_stage_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pix_in = '0;
    logic [1:0] ovl_in = '0;
    logic       vsync_in = 1'b0;
    logic [7:0] read_mask = '0;
    logic [7:0] blink_mask = '0;
    logic [7:0] cmd_in = '0;
    logic [7:0] pal_addr;
    logic [1:0] ovl_sel;
    logic       pal_sel;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    int       m_cnt  = 0;
    bit [1:0] m_rate = 0;
    bit       m_vsq  = 0;

    always #5 clk = ~clk;

    ovb_mask_stage u_ovb_mask_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_in     (pix_in),
        .ovl_in     (ovl_in),
        .vsync_in   (vsync_in),
        .read_mask  (read_mask),
        .blink_mask (blink_mask),
        .cmd_in     (cmd_in),
        .pal_addr   (pal_addr),
        .ovl_sel    (ovl_sel),
        .pal_sel    (pal_sel)
    );

    function automatic int on_len(input bit [1:0] r);
        case (r)
            2'd0, 2'd1: return 16;
            2'd2:       return 32;
            default:    return 64;
        endcase
    endfunction

    function automatic int period(input bit [1:0] r);
        case (r)
            2'd0:    return 64;
            2'd1:    return 32;
            2'd2:    return 64;
            default: return 128;
        endcase
    endfunction

    function automatic logic [7:0] exp_pix(input logic [7:0] p, input logic [7:0] rm,
                                           input logic [7:0] bm, input bit off);
        return p & rm & (off ? ~bm : 8'hFF);
    endfunction

    function automatic logic [1:0] exp_ovl(input logic [1:0] o, input logic [7:0] c, input bit off);
        logic [1:0] e;
        for (int i = 0; i < 2; i++) e[i] = o[i] & c[i] & ~(c[2+i] & off);
        return e;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: predict from model and current inputs, step, compare
    task automatic cycle();
        bit         off;
        logic [7:0] ep;
        logic [1:0] eo;
        logic       es;
        off = (m_cnt >= on_len(m_rate));
        ep  = exp_pix(pix_in, read_mask, blink_mask, off);
        eo  = exp_ovl(ovl_in, cmd_in, off);
        es  = (eo == 2'b00) && cmd_in[6];
        @(posedge clk);
        if (cmd_in[5:4] != m_rate) begin
            m_cnt  = 0;
            m_rate = cmd_in[5:4];
        end else if (vsync_in && !m_vsq) begin
            m_cnt = (m_cnt == period(m_rate) - 1) ? 0 : m_cnt + 1;
        end
        m_vsq = vsync_in;
        #1;
        chk(off ? "R3 off-phase pixel" : "R2 on-phase pixel", pal_addr, ep);
        chk((cmd_in[3:2] != 0) ? "R8 overlay blink" : "R7 overlay enable", {6'd0, ovl_sel}, {6'd0, eo});
        chk((eo != 0) ? "R10 overlay override" : "R9 source select", {7'd0, pal_sel}, {7'd0, es});
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            vsync_in = 1'b1; cycle();
            vsync_in = 1'b0; cycle();
        end
    endtask

    // Put the timer at count 0 of rate r (pass through another rate first)
    task automatic restart(input bit [1:0] r, input logic [7:0] low_cmd);
        cmd_in = {1'b0, low_cmd[6], 2'(r + 2'd1), low_cmd[3:0]}; cycle();
        cmd_in = {1'b0, low_cmd[6], r, low_cmd[3:0]};           cycle();
    endtask

    initial begin
        #(2_000_000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: drive busy inputs while reset is held
        pix_in = 8'hFF; read_mask = 8'hFF; ovl_in = 2'b11; cmd_in = 8'h43;
        repeat (4) @(posedge clk);
        #1;
        chk("R1 reset pal_addr", pal_addr, 8'h00);
        chk("R1 reset ovl_sel", {6'd0, ovl_sel}, 8'h00);
        chk("R1 reset pal_sel", {7'd0, pal_sel}, 8'h00);
        rst_n = 1'b1;
        cmd_in = 8'h00; ovl_in = 2'b00;
        blink_mask = 8'hFF;
        cycle();
        // R1: timer begins in the on phase after reset
        chk("R1 timer starts on", pal_addr, 8'hFF);

        // R4: phase lengths for every rate, observed on pal_addr
        for (int r = 0; r < 4; r++) begin
            restart(2'(r), 8'h00);
            pulse(on_len(2'(r)) - 1);
            chk("R4 last on period", pal_addr, 8'hFF);
            pulse(1);
            chk("R4 first off period", pal_addr, 8'h00);
            pulse(period(2'(r)) - on_len(2'(r)) - 1);
            chk("R4 last off period", pal_addr, 8'h00);
            pulse(1);
            chk("R4 wrap to on", pal_addr, 8'hFF);
        end

        // R5: a held high level counts one edge only
        restart(2'd1, 8'h00);
        pulse(15);
        vsync_in = 1'b1;
        repeat (30) cycle();
        chk("R5 level held high", pal_addr, 8'h00);
        vsync_in = 1'b0;
        repeat (30) cycle();
        chk("R5 level held low", pal_addr, 8'h00);

        // R6: rate change in the off phase restarts on
        restart(2'd3, 8'h00);
        pulse(70);
        chk("R6 precondition off", pal_addr, 8'h00);
        cmd_in = 8'h20; cycle();
        chk("R6 old phase this edge", pal_addr, 8'h00);
        cycle();
        chk("R6 restart on", pal_addr, 8'hFF);

        // R7, R9, R10 directed overlay cases
        ovl_in = 2'b11; cmd_in = 8'h20; cycle();
        chk("R7 disabled overlay", {6'd0, ovl_sel}, 8'h00);
        chk("R9 overlay color 0", {7'd0, pal_sel}, 8'h00);
        cmd_in = 8'h63; cycle();
        chk("R10 overlay 3 wins", {6'd0, ovl_sel}, 8'h03);
        chk("R10 palette off", {7'd0, pal_sel}, 8'h00);
        ovl_in = 2'b10; cmd_in = 8'h61; cycle();
        chk("R9 palette source", {7'd0, pal_sel}, 8'h01);

        // R8: overlay bit 0 blinks, bit 1 steady
        restart(2'd1, 8'h07);
        ovl_in = 2'b11; cycle();
        chk("R8 on phase overlay", {6'd0, ovl_sel}, 8'h03);
        pulse(16);
        chk("R8 off phase overlay", {6'd0, ovl_sel}, 8'h02);
        pulse(16);
        chk("R8 back on overlay", {6'd0, ovl_sel}, 8'h03);

        // R11: output moves only at the edge
        ovl_in = 2'b00; cmd_in = 8'h10; blink_mask = 8'h00;
        pix_in = 8'h5A; cycle();
        pix_in = 8'hA5; #2;
        chk("R11 held between edges", pal_addr, 8'h5A);
        cycle();
        chk("R11 one cycle latency", pal_addr, 8'hA5);

        // Random traffic against the model
        for (int i = 0; i < 6000; i++) begin
            pix_in   = 8'($urandom);
            ovl_in   = 2'($urandom);
            vsync_in = ($urandom % 3) == 0;
            if (($urandom % 16) == 0) begin
                read_mask  = 8'($urandom);
                blink_mask = 8'($urandom);
            end
            if (($urandom % 64) == 0) cmd_in = {1'b0, 7'($urandom)};
            cycle();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule